// File: doc/BRIEF.md
# Error Event Counter with Snapshot Buffer

This block counts error events in a 16-bit saturating counter and presents the count to software through a shadow buffer, read as a low byte and a high byte. Two snapshot schemes are supported. In demand-freeze mode, software writes a one to a hold bit. This stops the buffer so that both bytes belong to the same snapshot, and it clears the live counter. Reading the high byte drops the hold bit again, and the buffer resumes tracking.

In periodic mode, each pulse of an external one-second tick copies the counter into the buffer and restarts the count. Every tick also sets a sticky seconds flag. Software clears that flag by writing one to it, and it then has until the next tick to read the latched value. The error detector and the one-second timebase are outside this block.

Top module: `errlat_top`

## Requirements
- R1: With the hold bit at 0 and periodic mode off, the buffer is loaded with the live counter on every clock, so the buffer shows the count one cycle late.
- R2: A write of 1 to the hold bit while it is 0 clears the live counter at that edge. The buffer takes the pre-clear count at the same edge. From the next cycle the hold bit reads 1, and the buffer holds while the hold bit is 1 in demand mode.
- R3: A high-byte read strobe clears the hold bit at the next edge. A hold-bit write in the same cycle takes priority over the read.
- R4: In periodic mode, a tick copies the live counter into the buffer and clears the counter at the same edge. Between ticks the buffer holds.
- R5: Every tick sets the seconds flag, in either mode. The flag stays set until a flag-clear strobe arrives in a cycle with no tick.
- R6: The counter stops at 0xFFFF and does not wrap.
- R7: An error pulse in the same cycle as a counter clear leaves the counter at 1.
- R8: A low-byte read strobe has no effect on the hold bit, the counter or the buffer.
- R9: After synchronous reset, the counter, buffer, hold bit and flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | 1 | One error event per cycle when high |
| sec_tick | input | 1 | One-cycle pulse once per second |
| periodic_mode | input | 1 | 1 selects the tick-driven snapshot; 0 selects demand freeze |
| hold_wr | input | 1 | Write strobe for the hold bit |
| hold_wdata | input | 1 | Value written to the hold bit |
| flag_clr | input | 1 | Write-one strobe that clears the seconds flag |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| buf_lo | output | 8 | Buffer bits 7:0 |
| buf_hi | output | 8 | Buffer bits 15:8 |
| hold_bit | output | 1 | Current hold bit |
| sec_flag | output | 1 | Sticky seconds flag |

## Verification
The embedded properties check on every cycle:
- saturation at the top of the range;
- the restart value after a clear, with or without a coincident error;
- the hold bit dropping after a high-byte read;
- the buffer staying stable while held;
- the buffer taking the counter on a tick;
- the flag rising on every tick.

Only the bench's scenarios can show the end-to-end behaviour, because the count is not visible at the ports. This covers the one-cycle lag of the tracking buffer, the exact counts latched across freeze and tick sequences, mode switches in the middle of a count, and the lack of any side effect from a low-byte read.

// File: rtl/errlat_pkg.sv
package errlat_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        logic clr;       // restart counter this edge
        logic buf_load;  // copy counter into buffer this edge
        logic hold;      // registered hold bit
    } ctl_t;

    function automatic cnt_t next_count(cnt_t cur, logic clr, logic err);
        if (clr)
            return err ? cnt_t'(1) : cnt_t'(0);
        if (err && cur != CNT_MAX)
            return cur + cnt_t'(1);
        return cur;
    endfunction
endpackage

// File: rtl/errlat_counter.sv
module errlat_counter
    import errlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err,
    input  logic clr,
    output cnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= next_count(cnt, clr, err);
    end

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
    a_r7_err_on_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && err) |=> cnt == cnt_t'(1));
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (clr && !err) |=> cnt == '0);
endmodule

// File: rtl/errlat_ctrl.sv
module errlat_ctrl
    import errlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic periodic_mode,
    input  logic hold_wr,
    input  logic hold_wdata,
    input  logic flag_clr,
    input  logic rd_lo,
    input  logic rd_hi,
    output ctl_t ctl,
    output logic sec_flag
);
    logic hold_q;
    logic hold_rise;

    assign hold_rise    = hold_wr && hold_wdata && !hold_q;
    assign ctl.hold     = hold_q;
    assign ctl.clr      = hold_rise || (periodic_mode && sec_tick);
    assign ctl.buf_load = periodic_mode ? sec_tick : !hold_q;

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= 1'b0;
        else if (hold_wr) hold_q <= hold_wdata;
        else if (rd_hi)   hold_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)           sec_flag <= 1'b0;
        else if (sec_tick) sec_flag <= 1'b1;
        else if (flag_clr) sec_flag <= 1'b0;
    end

    a_r3_hi_read_releases: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !hold_wr) |=> !hold_q);
    a_r8_lo_read_inert: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !rd_hi && !hold_wr) |=> $stable(hold_q));
    a_r5_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> sec_flag);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (sec_flag && !flag_clr) |=> sec_flag);
endmodule

// File: rtl/errlat_shadow.sv
module errlat_shadow
    import errlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic periodic_mode,
    input  logic sec_tick,
    input  ctl_t ctl,
    input  cnt_t cnt,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi
);
    cnt_t shadow;

    always_ff @(posedge clk) begin
        if (rst)               shadow <= '0;
        else if (ctl.buf_load) shadow <= cnt;
    end

    assign lo = shadow[BYTE_W-1:0];
    assign hi = shadow[CNT_W-1:BYTE_W];

    a_r2_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && !periodic_mode) |=> $stable(shadow));
    a_r4_tick_latch: assert property (@(posedge clk) disable iff (rst)
        (periodic_mode && sec_tick) |=> shadow == $past(cnt));
    a_r4_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (periodic_mode && !sec_tick) |=> $stable(shadow));
endmodule

// File: rtl/errlat_top.sv
module errlat_top
    import errlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       err_pulse,
    input  logic       sec_tick,
    input  logic       periodic_mode,
    input  logic       hold_wr,
    input  logic       hold_wdata,
    input  logic       flag_clr,
    input  logic       rd_lo,
    input  logic       rd_hi,
    output logic [7:0] buf_lo,
    output logic [7:0] buf_hi,
    output logic       hold_bit,
    output logic       sec_flag
);
    ctl_t ctl;
    cnt_t cnt;

    errlat_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .periodic_mode(periodic_mode),
        .hold_wr(hold_wr), .hold_wdata(hold_wdata), .flag_clr(flag_clr),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .ctl(ctl), .sec_flag(sec_flag)
    );

    errlat_counter u_cnt (
        .clk(clk), .rst(rst), .err(err_pulse), .clr(ctl.clr), .cnt(cnt)
    );

    errlat_shadow u_shadow (
        .clk(clk), .rst(rst), .periodic_mode(periodic_mode), .sec_tick(sec_tick),
        .ctl(ctl), .cnt(cnt), .lo(buf_lo), .hi(buf_hi)
    );

    assign hold_bit = ctl.hold;
endmodule

// File: tb/errlat_top_test.sv
`timescale 1ns/1ps
module errlat_top_test;
    logic clk = 0;
    logic rst = 1;
    logic err_pulse = 0, sec_tick = 0, periodic_mode = 0;
    logic hold_wr = 0, hold_wdata = 0, flag_clr = 0, rd_lo = 0, rd_hi = 0;
    logic [7:0] buf_lo, buf_hi;
    logic hold_bit, sec_flag;

    int n_cmp = 0, n_bad = 0;
    int m_cnt = 0, m_buf = 0, m_hold = 0, m_flag = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    errlat_top uut (.*);

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sample at negedge: compare every output against the model.
    task automatic compare(string req);
        chk(req, "buffer", {buf_hi, buf_lo}, m_buf);
        chk(req, "hold_bit", hold_bit, m_hold);
        chk(req, "sec_flag", sec_flag, m_flag);
    endtask

    // Drive one cycle: set inputs, advance the model, wait for the edge, then compare.
    task automatic step(string req, bit e, bit t, bit pm, bit hw, bit hd,
                        bit fc, bit rl, bit rh);
        bit rise, clr, load;
        int n_cnt, n_buf, n_hold, n_flag;
        err_pulse = e; sec_tick = t; periodic_mode = pm; hold_wr = hw;
        hold_wdata = hd; flag_clr = fc; rd_lo = rl; rd_hi = rh;
        rise = hw && hd && (m_hold == 0);
        clr  = rise || (pm && t);
        load = pm ? t : (m_hold == 0);
        n_buf  = load ? m_cnt : m_buf;
        if (clr)                        n_cnt = e ? 1 : 0;
        else if (e && m_cnt < 65535)    n_cnt = m_cnt + 1;
        else                            n_cnt = m_cnt;
        n_hold = hw ? int'(hd) : (rh ? 0 : m_hold);
        n_flag = t ? 1 : (fc ? 0 : m_flag);
        @(posedge clk);
        m_cnt = n_cnt; m_buf = n_buf; m_hold = n_hold; m_flag = n_flag;
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(5.0 * 190000);
        $display("FAIL watchdog expired");
        n_bad++; n_cmp++;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R9");                           // R9 reset state
        repeat (10) step("R1", 1,0,0,0,0,0,0,0); // R1 tracking
        step("R1", 0,0,0,0,0,0,0,0);
        chk("R1", "buffer after 10 errors", {buf_hi, buf_lo}, 10);
        step("R2", 1,0,0,1,1,0,0,0);             // R2 freeze with error -> R7
        repeat (5) step("R2", 1,0,0,0,0,0,0,0);
        chk("R2", "held buffer", {buf_hi, buf_lo}, 10);
        step("R8", 0,0,0,0,0,0,1,0);             // R8 low read inert
        chk("R8", "hold after low read", hold_bit, 1);
        step("R3", 0,0,0,0,0,0,0,1);             // R3 high read releases
        chk("R3", "hold after high read", hold_bit, 0);
        step("R3", 0,0,0,0,0,0,0,0);
        chk("R7", "count with error at clear", {buf_hi, buf_lo}, 6);
        step("R3", 0,0,0,1,1,0,0,1);             // R3 write beats read
        chk("R3", "write wins", hold_bit, 1);
        step("R3", 0,0,0,0,0,0,0,1);
        // R4/R5 periodic mode
        repeat (7) step("R4", 1,0,1,0,0,0,0,0);
        step("R4", 0,1,1,0,0,0,0,0);
        chk("R4", "tick latch", {buf_hi, buf_lo}, 7);
        chk("R5", "flag set", sec_flag, 1);
        step("R5", 0,0,1,0,0,1,0,0);
        chk("R5", "flag cleared", sec_flag, 0);
        step("R5", 1,1,1,0,0,1,0,0);
        chk("R5", "tick beats clear", sec_flag, 1);
        chk("R4", "counter cleared by tick", {buf_hi, buf_lo}, 0);
        step("R7", 0,1,1,0,0,0,0,0);
        chk("R7", "error at tick counted", {buf_hi, buf_lo}, 1);
        // R6 saturation
        step("R6", 0,1,1,0,0,0,0,0);
        repeat (70000) step("R6", 1,0,1,0,0,0,0,0);
        step("R6", 1,1,1,0,0,0,0,0);
        chk("R6", "saturated latch", {buf_hi, buf_lo}, 16'hFFFF);
        // mixed random traffic
        for (int i = 0; i < 20000; i++) begin
            step("R1", $urandom_range(0,2) != 0, $urandom_range(0,40) == 0,
                 (i / 3000) % 2 == 1, $urandom_range(0,60) == 0, $urandom_range(0,1) == 1,
                 $urandom_range(0,10) == 0, $urandom_range(0,8) == 0,
                 $urandom_range(0,30) == 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule